// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy-Mapping Autodetect

This block takes the level-sensitive INTA..INTD pins of several PCI slots and merges them onto four system interrupt lines. In normal operation each pin is rotated onto an output by the usual slot-based swizzle. The rotation offset depends on a board-variant strap, because the two supported board wirings connect the pins one position apart.

Some older guest software expects a non-swizzled routing. The block finds out which routing software wants by snooping configuration writes to each function's interrupt-line register (offset 0x3C). A three-state mode register starts in a reset default, normally "assume correct". The first write it can classify moves it to "legacy" or to "forced correct", and from then on it holds that state until the next reset. Forwarding the configuration cycle, the bus protocol and the interrupt controller all sit outside this block.

Top module: `pir_intx_router`

## Requirements
- R1: On each clock edge with `rst_n` low, `mode` loads `mode_default`. The mode encoding is 0 = assume-correct, 1 = legacy, 2 = forced-correct. A default of 3 loads assume-correct, and `mode` never reads 3.
- R2: A snooped write is classified only when all of the following hold: `cfg_wr_valid` is 1, `board_variant` is 0, `cfg_wr_addr[7:0]` equals 0x3C, and `mode` is assume-correct. The new mode is visible after the next rising clock edge. Any other write leaves `mode` unchanged.
- R3: The slot of a write is the device number `cfg_wr_addr[15:11]`, taken modulo 4. A written value of 27 leaves assume-correct unchanged when the slot modulo 4 is 2, and selects legacy for any other slot.
- R4: A written value equal to (slot mod 4)+27, or to (slot mod 4)+91, selects legacy.
- R5: Any other written value selects forced-correct.
- R6: Once `mode` is legacy or forced-correct, it stays unchanged until reset, whatever is written.
- R7: Slot array index i carries its pins in `slot_intx[4*i+3:4*i]`, with pin 0 = INTA, and has slot number FIRST_SLOT+i. With `board_variant` = 0 and `mode` not legacy, pin p of slot s drives `irq_out[(p+2+s) mod 4]`.
- R8: With `board_variant` = 1, pin p of slot s drives `irq_out[(p+3+s) mod 4]` in every mode.
- R9: With `board_variant` = 0 and `mode` legacy, pin p of every slot drives `irq_out[p]`.
- R10: Each output is the OR of all pins routed to it. The routing is combinational, with no register between `slot_intx` and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_valid | input | 1 | Snooped configuration write is present |
| cfg_wr_addr | input | 16 | Device/function byte in [15:8], register offset in [7:0] |
| cfg_wr_data | input | 8 | Byte written |
| board_variant | input | 1 | Board wiring strap (0 or 1) |
| mode_default | input | 2 | Mode loaded during reset |
| slot_intx | input | 4*NUM_SLOTS | INTA..INTD levels per slot |
| irq_out | output | 4 | System interrupt lines |
| mode | output | 2 | Current routing mode |

## Verification
The assertions assume that `board_variant` is a static strap and that `mode_default` only matters while reset is asserted. The stimulus changes the strap only between scenarios, and only while no qualifying write is in flight. The checker also assumes that the interrupt levels are plain combinational inputs, so it compares `irq_out` against `slot_intx` within the same cycle. The bench drives every input on the falling edge and reads the outputs half a cycle later.

// File: rtl/pir_pkg.sv
package pir_pkg;
   typedef enum logic [1:0] {
      MODE_ASSUME_OK = 2'd0,
      MODE_LEGACY    = 2'd1,
      MODE_FORCE_OK  = 2'd2
   } pir_mode_e;

   localparam int PIR_PINS = 4;
endpackage

// File: rtl/pir_classify.sv
module pir_classify
   import pir_pkg::*;
#(
   parameter int LINE_BASE   = 27,
   parameter int ALT_OFFSET  = 64,
   parameter int SHARED_SLOT = 2
) (
   input  logic [1:0] slot_lo,
   input  logic [7:0] value,
   output pir_mode_e  verdict
);
   initial begin
      if (LINE_BASE + 3 + ALT_OFFSET > 255) $error("pir_classify: values exceed 8 bits");
      if (SHARED_SLOT < 0 || SHARED_SLOT > 3) $error("pir_classify: SHARED_SLOT out of range");
   end

   logic [7:0] direct_val;
   logic [7:0] alt_val;

   assign direct_val = 8'(LINE_BASE) + {6'd0, slot_lo};
   assign alt_val    = direct_val + 8'(ALT_OFFSET);

   always_comb begin
      if (value == 8'(LINE_BASE)) begin
         verdict = (slot_lo == 2'(SHARED_SLOT)) ? MODE_ASSUME_OK : MODE_LEGACY;
      end else if (value == direct_val || value == alt_val) begin
         verdict = MODE_LEGACY;
      end else begin
         verdict = MODE_FORCE_OK;
      end
   end
endmodule

// File: rtl/pir_mode_reg.sv
module pir_mode_reg
   import pir_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_default,
   input  logic       snoop_hit,
   input  pir_mode_e  verdict,
   output pir_mode_e  mode_q
);
   pir_mode_e reset_mode;

   assign reset_mode = (mode_default == 2'd3) ? MODE_ASSUME_OK : pir_mode_e'(mode_default);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= reset_mode;
      end else if (snoop_hit && mode_q == MODE_ASSUME_OK) begin
         mode_q <= verdict;
      end
   end
endmodule

// File: rtl/pir_swizzle.sv
module pir_swizzle
   import pir_pkg::*;
#(
   parameter int NUM_SLOTS  = 4,
   parameter int FIRST_SLOT = 12,
   parameter int OFS_VAR0   = 2,
   parameter int OFS_VAR1   = 3
) (
   input  logic [PIR_PINS*NUM_SLOTS-1:0] slot_intx,
   input  logic                          board_variant,
   input  logic                          passthru,
   output logic [PIR_PINS-1:0]           irq_out
);
   logic [PIR_PINS-1:0] contrib [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam int SLOT_LO = (FIRST_SLOT + g) % PIR_PINS;
      always_comb begin
         contrib[g] = '0;
         for (int p = 0; p < PIR_PINS; p++) begin
            logic [1:0] idx;
            if (passthru) begin
               idx = 2'(p);
            end else if (board_variant) begin
               idx = 2'(p + OFS_VAR1 + SLOT_LO);
            end else begin
               idx = 2'(p + OFS_VAR0 + SLOT_LO);
            end
            contrib[g][idx] = contrib[g][idx] | slot_intx[PIR_PINS*g + p];
         end
      end
   end

   always_comb begin
      irq_out = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         irq_out = irq_out | contrib[s];
      end
   end
endmodule

// File: rtl/pir_intx_router.sv
module pir_intx_router
   import pir_pkg::*;
#(
   parameter int NUM_SLOTS    = 4,
   parameter int FIRST_SLOT   = 12,
   parameter int LINE_OFS     = 8'h3C,
   parameter int LINE_BASE    = 27,
   parameter int ALT_OFFSET   = 64,
   localparam int INTX_W      = PIR_PINS * NUM_SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_valid,
   input  logic [15:0]       cfg_wr_addr,
   input  logic [7:0]        cfg_wr_data,
   input  logic              board_variant,
   input  logic [1:0]        mode_default,
   input  logic [INTX_W-1:0] slot_intx,
   output logic [3:0]        irq_out,
   output logic [1:0]        mode
);
   initial begin
      if (NUM_SLOTS < 1 || NUM_SLOTS > 32) $error("pir_intx_router: NUM_SLOTS out of range");
      if (FIRST_SLOT < 0 || FIRST_SLOT + NUM_SLOTS > 32) $error("pir_intx_router: slot range exceeds 32 devices");
      if (LINE_OFS < 0 || LINE_OFS > 255) $error("pir_intx_router: LINE_OFS must fit a byte");
   end

   logic       snoop_hit;
   pir_mode_e  verdict;
   pir_mode_e  mode_q;
   logic [5:0] unused_addr_bits;

   assign unused_addr_bits = {cfg_wr_addr[15:13], cfg_wr_addr[10:8]};
   assign snoop_hit = cfg_wr_valid && !board_variant && (cfg_wr_addr[7:0] == 8'(LINE_OFS));

   pir_classify #(
      .LINE_BASE  (LINE_BASE),
      .ALT_OFFSET (ALT_OFFSET),
      .SHARED_SLOT(2)
   ) u_classify (
      .slot_lo(cfg_wr_addr[12:11]),
      .value  (cfg_wr_data),
      .verdict(verdict)
   );

   pir_mode_reg u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_default(mode_default),
      .snoop_hit   (snoop_hit),
      .verdict     (verdict),
      .mode_q      (mode_q)
   );

   pir_swizzle #(
      .NUM_SLOTS (NUM_SLOTS),
      .FIRST_SLOT(FIRST_SLOT),
      .OFS_VAR0  (2),
      .OFS_VAR1  (3)
   ) u_swz (
      .slot_intx    (slot_intx),
      .board_variant(board_variant),
      .passthru     (mode_q == MODE_LEGACY && !board_variant),
      .irq_out      (irq_out)
   );

   assign mode = mode_q;
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
   parameter int NUM_SLOTS = 4,
   parameter int LINE_OFS  = 8'h3C
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_wr_valid,
   input logic [7:0]             cfg_ofs,
   input logic                   board_variant,
   input logic [4*NUM_SLOTS-1:0] slot_intx,
   input logic [3:0]             irq_out,
   input logic [1:0]             mode
);
   logic [3:0] pin_or;
   always_comb begin
      pin_or = '0;
      for (int s = 0; s < NUM_SLOTS; s++) pin_or = pin_or | slot_intx[4*s +: 4];
   end

   // R1
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

   // R2
   no_stray_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr_valid && !board_variant && cfg_ofs == 8'(LINE_OFS)) |=> $stable(mode));

   // R6
   sticky_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0) |=> $stable(mode));

   // R9
   legacy_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && !board_variant) |-> (irq_out == pin_or));

   // R10
   quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_intx == '0) |-> (irq_out == 4'd0));

   // R10
   active_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_intx != '0) |-> (irq_out != 4'd0));
endmodule

bind pir_intx_router pir_checker #(
   .NUM_SLOTS(NUM_SLOTS),
   .LINE_OFS (LINE_OFS)
) u_pir_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_valid (cfg_wr_valid),
   .cfg_ofs      (cfg_wr_addr[7:0]),
   .board_variant(board_variant),
   .slot_intx    (slot_intx),
   .irq_out      (irq_out),
   .mode         (mode)
);

// File: tb/pir_intx_router_bench.sv
module pir_intx_router_bench;
   localparam int NS = 4;
   localparam int FS = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_valid = 1'b0;
   logic [15:0]   cfg_wr_addr = '0;
   logic [7:0]    cfg_wr_data = '0;
   logic          board_variant = 1'b0;
   logic [1:0]    mode_default = 2'd0;
   logic [4*NS-1:0] slot_intx = '0;
   logic [3:0]    irq_out;
   logic [1:0]    mode;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pir_intx_router #(.NUM_SLOTS(NS), .FIRST_SLOT(FS)) u_pir_intx_router (
      .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr),
      .cfg_wr_data(cfg_wr_data), .board_variant(board_variant), .mode_default(mode_default),
      .slot_intx(slot_intx), .irq_out(irq_out), .mode(mode));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(logic [1:0] dflt);
      @(negedge clk);
      rst_n = 1'b0; mode_default = dflt; cfg_wr_valid = 1'b0; slot_intx = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic cfg_write(logic [4:0] dev, logic [7:0] ofs, logic [7:0] val);
      @(negedge clk);
      cfg_wr_valid = 1'b1; cfg_wr_addr = {dev, 3'd0, ofs}; cfg_wr_data = val;
      @(negedge clk);
      cfg_wr_valid = 1'b0;
      #1;
   endtask

   task automatic sweep_routes(string req, int ofs, logic legacy);
      for (int i = 0; i < NS; i++) begin
         for (int p = 0; p < 4; p++) begin
            int e;
            slot_intx = '0;
            slot_intx[4*i + p] = 1'b1;
            #1;
            e = legacy ? p : (p + ofs + FS + i) % 4;
            check(req, 32'(irq_out), 32'(4'b1 << e));
         end
      end
      slot_intx = '0;
   endtask

   task automatic t_reset;
      do_reset(2'd0);
      check("R1 reset mode", 32'(mode), 32'd0);
      check("R10 idle lines", 32'(irq_out), 32'd0);
      do_reset(2'd1);
      check("R1 default legacy", 32'(mode), 32'd1);
      do_reset(2'd2);
      check("R1 default forced", 32'(mode), 32'd2);
      do_reset(2'd3);
      check("R1 default 3", 32'(mode), 32'd0);
   endtask

   task automatic t_swizzle;
      board_variant = 1'b0;
      do_reset(2'd0);
      sweep_routes("R7 variant0 swizzle", 2, 1'b0);
      board_variant = 1'b1;
      do_reset(2'd0);
      sweep_routes("R8 variant1 swizzle", 3, 1'b0);
      do_reset(2'd1);
      sweep_routes("R8 variant1 ignores legacy", 3, 1'b0);
      board_variant = 1'b0;
   endtask

   task automatic t_or_merge;
      do_reset(2'd0);
      // slot idx0 (s=12) pin2 -> 0 ; slot idx1 (s=13) pin1 -> 0
      slot_intx = '0; slot_intx[2] = 1'b1; slot_intx[5] = 1'b1;
      #1 check("R10 two pins merged", 32'(irq_out), 32'b0001);
      slot_intx[2] = 1'b0;
      #1 check("R10 one pin remains", 32'(irq_out), 32'b0001);
      slot_intx[5] = 1'b0; slot_intx[15] = 1'b1; // idx3 s=15 pin3 -> (3+2+3)%4=0
      #1 check("R10 combinational change", 32'(irq_out), 32'b0001);
      slot_intx = '0;
   endtask

   task automatic t_detect;
      do_reset(2'd0);
      cfg_write(5'd2, 8'h3C, 8'd27);
      check("R3 27 on slot 2 keeps", 32'(mode), 32'd0);
      cfg_write(5'd6, 8'h3C, 8'd27);
      check("R3 27 on slot 6 keeps", 32'(mode), 32'd0);
      cfg_write(5'd4, 8'h3C, 8'd27);
      check("R3 27 on slot 4 legacy", 32'(mode), 32'd1);
      cfg_write(5'd1, 8'h3C, 8'd77);
      check("R6 legacy sticky", 32'(mode), 32'd1);
      sweep_routes("R9 legacy passthru", 0, 1'b1);
      do_reset(2'd0);
      cfg_write(5'd1, 8'h3C, 8'd28);
      check("R4 slot+27 legacy", 32'(mode), 32'd1);
      do_reset(2'd0);
      cfg_write(5'd11, 8'h3C, 8'd94);
      check("R4 slot+91 legacy", 32'(mode), 32'd1);
      do_reset(2'd0);
      cfg_write(5'd1, 8'h3C, 8'd29);
      check("R5 off-by-one forced", 32'(mode), 32'd2);
      do_reset(2'd0);
      cfg_write(5'd0, 8'h3C, 8'd50);
      check("R5 other value forced", 32'(mode), 32'd2);
      cfg_write(5'd1, 8'h3C, 8'd27);
      check("R6 forced sticky", 32'(mode), 32'd2);
      sweep_routes("R7 forced swizzle", 2, 1'b0);
   endtask

   task automatic t_ignored;
      do_reset(2'd0);
      cfg_write(5'd0, 8'h3D, 8'd27);
      check("R2 wrong offset ignored", 32'(mode), 32'd0);
      @(negedge clk);
      cfg_wr_addr = {5'd0, 3'd0, 8'h3C}; cfg_wr_data = 8'd27; cfg_wr_valid = 1'b0;
      @(negedge clk); #1;
      check("R2 invalid ignored", 32'(mode), 32'd0);
      board_variant = 1'b1;
      do_reset(2'd0);
      cfg_write(5'd0, 8'h3C, 8'd27);
      check("R2 variant1 ignored", 32'(mode), 32'd0);
      board_variant = 1'b0;
      cfg_write(5'd0, 8'h3C, 8'd91);
      check("R4 phase alt slot0", 32'(mode), 32'd1);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_swizzle();
      t_or_merge();
      t_detect();
      t_ignored();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule